// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Read Latency

This block is a synthesizable synchronous SRAM with a parameterised depth and a word built from several byte lanes. Every command is sampled on the rising clock edge. A static mode pin sets the read latency. In pipelined mode, read data passes through an output register. In flow-through mode, read data comes straight from the array. Write data arrives the same number of cycles after its address as read data leaves after its address. This lets reads and writes alternate on every cycle with no idle cycle in between.

A command is a write when the global write is high, or when the byte-write enable is high together with at least one lane select. Any other accepted command is a read. The output side is a valid-qualified stream with no back-pressure. `rd_valid` is high for exactly one cycle per accepted read, and the consumer must take the word in that cycle. Output enable and sleep act on the output without waiting for a clock edge. While sleep is high, the block also ignores new commands and performs no array writes.

Top module: `ssram_core`

## Requirements
- R1: After reset, and until the first accepted read has reached the output, `rd_valid` is 0 and `rd_data` is zero.
- R2: With `pipe_mode`=1, a read accepted at clock edge n shows its word with `rd_valid`=1 only in the cycle after edge n+1.
- R3: With `pipe_mode`=0, a read accepted at clock edge n shows its word with `rd_valid`=1 only in the cycle after edge n.
- R4: The write data for a write accepted at edge n is sampled from `wr_data` at edge n+2 in pipelined mode and at edge n+1 in flow-through mode.
- R5: Reads and writes can be issued on consecutive edges in any mix. A read issued right after a write to the same address returns the merged new word.
- R6: With `byte_wr_en`=1 and `all_wr`=0, lane i (bits i*8+7 down to i*8) is written only when `byte_sel[i]`=1. The other lanes keep their contents.
- R7: With `all_wr`=1, every lane is written, whatever the values of `byte_wr_en` and `byte_sel`.
- R8: An accepted command with `all_wr`=0 and with `byte_wr_en`=0 or `byte_sel`=0 is a read and changes no stored data.
- R9: While `out_en`=0, `rd_valid` is 0 and `rd_data` is zero. The effect does not wait for a clock edge.
- R10: While `sleep`=1, commands are ignored and the output is held at `rd_valid`=0 with `rd_data` zero. Stored contents are kept through sleep.
- R11: An edge with `req`=0 neither reads nor writes, whatever the values of the write controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control stages |
| pipe_mode | input | 1 | Static latency select: 1 pipelined, 0 flow-through |
| req | input | 1 | Command present this edge (chip enable) |
| all_wr | input | 1 | Global write: all lanes |
| byte_wr_en | input | 1 | Byte-write enable |
| byte_sel | input | LANES | Per-lane write selects |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*LANE_W | Delayed write data |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| rd_data | output | LANES*LANE_W | Read word, zero when not valid |
| rd_valid | output | 1 | Read word present this cycle |

## Verification
The scoreboard first runs a stream that alternates writes and reads on every edge. This shows whether the delay on write data matches the read latency, and whether a read placed right behind a write gets the merged word. Separate patterns then check how the write is decoded. Partial lane masks test which lanes are kept. A global write with byte selects cleared tests the override. A command with byte selects set but the enable low must act as a read. Idle edges that carry write controls test that nothing changes without `req`. Reads with output enable low and commands issued during sleep must leave the output quiet. A later read shows that the stored data was kept. Both latency modes run the write-then-read stream, so a latency error in either mode shows up as a mismatch in the cycle where the word arrives.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  function automatic int unsigned mode_latency(rd_mode_e m);
    return (m == MODE_PIPE) ? 2 : 1;
  endfunction
endpackage

// File: rtl/ssram_cmd_stage.sv
module ssram_cmd_stage #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_mask,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_mask,
  output logic              s2_vld,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_mask
);
  localparam int NSTG = 2;

  logic              vld_q  [NSTG];
  logic              wr_q   [NSTG];
  logic [ADDR_W-1:0] addr_q [NSTG];
  logic [LANES-1:0]  mask_q [NSTG];

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    logic              vld_d;
    logic              wr_d;
    logic [ADDR_W-1:0] addr_d;
    logic [LANES-1:0]  mask_d;
    if (g == 0) begin : g_head
      assign vld_d  = in_vld;
      assign wr_d   = in_wr;
      assign addr_d = in_addr;
      assign mask_d = in_mask;
    end else begin : g_tail
      assign vld_d  = vld_q[g-1];
      assign wr_d   = wr_q[g-1];
      assign addr_d = addr_q[g-1];
      assign mask_d = mask_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else        vld_q[g] <= vld_d;
      wr_q[g]   <= wr_d;
      addr_q[g] <= addr_d;
      mask_q[g] <= mask_d;
    end
  end

  assign s1_vld  = vld_q[0];
  assign s1_wr   = wr_q[0];
  assign s1_addr = addr_q[0];
  assign s1_mask = mask_q[0];
  assign s2_vld  = vld_q[1];
  assign s2_wr   = wr_q[1];
  assign s2_addr = addr_q[1];
  assign s2_mask = mask_q[1];
endmodule

// File: rtl/ssram_store.sv
module ssram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_word,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES*LANE_W-1:0] mem [DEPTH];
  logic [LANES*LANE_W-1:0] raw;
  logic                    hit;

  assign raw = mem[rd_addr];
  assign hit = wr_en && (wr_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[l])
        mem[wr_addr][l*LANE_W +: LANE_W] <= wr_word[l*LANE_W +: LANE_W];
    end
    assign rd_word[l*LANE_W +: LANE_W] = (hit && wr_mask[l]) ?
        wr_word[l*LANE_W +: LANE_W] : raw[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ssram_rd_out.sv
module ssram_rd_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssram_pkg::rd_mode_e mode,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              out_en,
  input  logic              sleep,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import ssram_pkg::*;

  logic              reg_vld;
  logic [DATA_W-1:0] reg_dat;
  logic              pick_vld;
  logic [DATA_W-1:0] pick_dat;

  always_ff @(posedge clk) begin
    if (!rst_n) reg_vld <= 1'b0;
    else        reg_vld <= rd_hit && !sleep && (mode == MODE_PIPE);
    reg_dat <= rd_word;
  end

  always_comb begin
    if (mode == MODE_PIPE) begin
      pick_vld = reg_vld;
      pick_dat = reg_dat;
    end else begin
      pick_vld = rd_hit;
      pick_dat = rd_word;
    end
  end

  assign rd_valid = pick_vld && out_en && !sleep;
  assign rd_data  = rd_valid ? pick_dat : '0;
endmodule

// File: rtl/ssram_core.sv
module ssram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    req,
  input  logic                    all_wr,
  input  logic                    byte_wr_en,
  input  logic [LANES-1:0]        byte_sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    out_en,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);
  import ssram_pkg::*;
  localparam int DATA_W = LANES * LANE_W;

  rd_mode_e          mode;
  logic              is_wr;
  logic [LANES-1:0]  mask;
  logic              s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr, c_addr;
  logic [LANES-1:0]  s1_mask, s2_mask, c_mask;
  logic              c_en;
  logic [DATA_W-1:0] rd_word;

  assign mode  = rd_mode_e'(pipe_mode);
  assign is_wr = all_wr || (byte_wr_en && (|byte_sel));
  assign mask  = all_wr ? {LANES{1'b1}} : (byte_wr_en ? byte_sel : '0);

  ssram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .in_vld(req && !sleep), .in_wr(is_wr), .in_addr(addr), .in_mask(mask),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_mask(s1_mask),
    .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_mask(s2_mask)
  );

  always_comb begin
    if (mode == MODE_PIPE) begin
      c_en   = s2_vld && s2_wr;
      c_addr = s2_addr;
      c_mask = s2_mask;
    end else begin
      c_en   = s1_vld && s1_wr;
      c_addr = s1_addr;
      c_mask = s1_mask;
    end
  end

  ssram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .wr_en(c_en && !sleep), .wr_addr(c_addr), .wr_mask(c_mask),
    .wr_word(wr_data), .rd_addr(s1_addr), .rd_word(rd_word)
  );

  ssram_rd_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_hit(s1_vld && !s1_wr), .rd_word(rd_word),
    .out_en(out_en), .sleep(sleep),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/ssram_core_chk.sv
module ssram_core_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              req,
  input logic              all_wr,
  input logic              byte_wr_en,
  input logic [LANES-1:0]  byte_sel,
  input logic              out_en,
  input logic              sleep,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);
  logic rd_cmd;
  assign rd_cmd = req && !sleep && !all_wr && !(byte_wr_en && (|byte_sel));

  assert_out_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!rd_valid && rd_data == '0));

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_valid);

  assert_flow_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_cmd) |=> (rd_valid || !out_en || sleep));

  assert_pipe_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_cmd) |=> ##1 (rd_valid || !out_en || sleep || $past(sleep)));

  assert_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !req) |=> !rd_valid);
endmodule

bind ssram_core ssram_core_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .req(req),
  .all_wr(all_wr), .byte_wr_en(byte_wr_en), .byte_sel(byte_sel),
  .out_en(out_en), .sleep(sleep), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/ssram_core_tb.sv
module ssram_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b1;
  logic          req = 1'b0, all_wr = 1'b0, byte_wr_en = 1'b0;
  logic [NL-1:0] byte_sel = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          out_en = 1'b1, sleep = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 2;
  logic [DW-1:0] slot0 = '0, slot1 = '0;
  logic [DW-1:0] model [1<<AW];

  typedef struct {
    int          due;
    logic [DW-1:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  ssram_core u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .req(req),
    .all_wr(all_wr), .byte_wr_en(byte_wr_en), .byte_sel(byte_sel),
    .addr(addr), .wr_data(wr_data), .out_en(out_en), .sleep(sleep),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops scoreboard items when they fall due
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        if (out_en && !sleep)
          check(rd_valid === 1'b1 && rd_data === it.exp, it.tag, rd_data, it.exp);
        else
          check(rd_valid === 1'b0 && rd_data === '0, {it.tag, " quiet"}, rd_data, '0);
      end else if (rd_valid !== 1'b0) begin
        check(1'b0, "R2/R3 unexpected valid", {31'd0, rd_valid}, '0);
      end
    end
  end

  task automatic drive(input logic r, input logic bwe, input logic [NL-1:0] bs,
                       input logic gw, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic oe, input logic slp, input string tag);
    logic w;
    item_t it;
    @(negedge clk);
    wr_data = slot0;
    slot0 = slot1;
    slot1 = '0;
    req = r; byte_wr_en = bwe; byte_sel = bs; all_wr = gw; addr = a;
    out_en = oe; sleep = slp;
    w = gw || (bwe && (|bs));
    if (r && !slp) begin
      if (w) begin
        for (int i = 0; i < NL; i++)
          if (gw || (bwe && bs[i])) model[a][i*8 +: 8] = d[i*8 +: 8];
        if (lat == 1) slot0 = d; else slot1 = d;
      end else begin
        it.due = cyc + lat;
        it.exp = model[a];
        it.tag = tag;
        sbq.push_back(it);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b1, 1'b0, "idle");
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive(1'b1, 1'b1, 4'hF, 1'b0, a, d, 1'b1, 1'b0, "R4 write");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    drive(1'b1, 1'b0, '0, 1'b0, a, '0, 1'b1, 1'b0, tag);
  endtask

  task automatic do_reset(input logic pm);
    @(negedge clk);
    rst_n = 1'b0; pipe_mode = pm; lat = pm ? 2 : 1;
    slot0 = '0; slot1 = '0;
    req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic suite(input string m);
    // R5: back-to-back alternation, read right behind write to same address
    for (int k = 0; k < 6; k++) begin
      wr(AW'(k + 1), 32'h1000_0000 * (k + 1) + 32'h0101 * k + 32'h5A);
      rd(AW'(k + 1), {"R5 rd-after-wr ", m});
    end
    rd(6'd1, {"R4 readback ", m});
    // R6: partial lane mask, then read at once
    drive(1'b1, 1'b1, 4'b0101, 1'b0, 6'd2, 32'hFFEE_DDCC, 1'b1, 1'b0, "R6 wr");
    rd(6'd2, {"R6 lanes ", m});
    drive(1'b1, 1'b1, 4'b1000, 1'b0, 6'd3, 32'h77AB_CDEF, 1'b1, 1'b0, "R6 wr");
    rd(6'd3, {"R6 top lane ", m});
    // R7: global write overrides cleared selects
    drive(1'b1, 1'b0, 4'b0000, 1'b1, 6'd4, 32'hC0DE_F00D, 1'b1, 1'b0, "R7 wr");
    rd(6'd4, {"R7 global ", m});
    // R8: selects without enable act as read
    drive(1'b1, 1'b0, 4'hF, 1'b0, 6'd5, 32'hDEAD_BEEF, 1'b1, 1'b0, {"R8 sel-no-en ", m});
    rd(6'd5, {"R8 unchanged ", m});
    // R11: write controls with req low
    drive(1'b0, 1'b1, 4'hF, 1'b1, 6'd6, 32'hBAD0_BAD0, 1'b1, 1'b0, "R11 noreq");
    idle(3);
    rd(6'd6, {"R11 unchanged ", m});
    idle(3);
    // R9: output enable low
    drive(1'b1, 1'b0, '0, 1'b0, 6'd1, '0, 1'b0, 1'b0, {"R9 oe-off ", m});
    drive(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, "idle");
    drive(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, "idle");
    idle(2);
    // R10: sleep ignores commands, output quiet, contents kept
    drive(1'b1, 1'b0, '0, 1'b1, 6'd4, 32'h0BAD_0BAD, 1'b1, 1'b1, "R10 wr");
    @(posedge clk); #2;
    check(rd_valid === 1'b0 && rd_data === '0, {"R10 sleep quiet ", m}, rd_data, '0);
    drive(1'b1, 1'b0, '0, 1'b0, 6'd4, '0, 1'b1, 1'b1, "R10 rd");
    @(posedge clk); #2;
    check(rd_valid === 1'b0 && rd_data === '0, {"R10 sleep rd ", m}, rd_data, '0);
    idle(4);
    rd(6'd4, {"R10 retained ", m});
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(rd_valid === 1'b0 && rd_data === '0, "R1 reset pipe", rd_data, '0);
    suite("R2 pipe");
    do_reset(1'b0);
    @(posedge clk); #2;
    check(rd_valid === 1'b0 && rd_data === '0, "R1 reset flow", rd_data, '0);
    suite("R3 flow");
    idle(4);
    check(sbq.size() == 0, "R2/R3 missing results", DW'(sbq.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule